// File: doc/BRIEF.md
# Hotspot Banked ROM Window Mapper

This block sits on the cartridge side of an 8-bit CPU bus with a 16-bit address. It turns each CPU address into a physical ROM address and a ROM enable. The lower 32 KB of the CPU map always reaches the same fixed base area of the ROM. The 16 KB range directly above it is a window, and the window shows whichever 16 KB bank is currently selected.

The bank is not chosen by writing a data value. Software picks it by touching one of a few reserved hotspot addresses starting at $C000, with either a read or a write. The low bits of the hotspot address give the bank number, and the new bank is in place from the next bus cycle on.

The ROM is only enabled for valid read cycles below $C000. The hotspots, the console RAM range at $C800–$CBFF and everything above are left alone. The bank-number width is a parameter. The default of 2 gives four banks, and a width of 5 gives 32 banks with 32 hotspots.

Top module: `hotspot_bank_mapper`

## Requirements
- R1: After synchronous reset the selected bank is 0, so a valid read of window address $8000+k maps to physical address $8000+k.
- R2: A valid read of any CPU address $0000–$7FFF maps to the identical physical address, whatever bank is selected.
- R3: A valid read of CPU address $8000–$BFFF maps to physical address $8000 + bank×$4000 + (address bits 13:0).
- R4: A valid read of hotspot address $C000+n (n below the bank count, n taken from the low BANK_W address bits) selects bank n.
- R5: A valid write to a hotspot address selects a bank in the same way as a read.
- R6: A new selection applies from the bus cycle immediately after the hotspot access. A hotspot address presented with bus_valid low does not change the selected bank.
- R7: rom_ce is 1 only when bus_valid is 1, cpu_rw is 1 (read) and the address is below $C000. Writes and addresses at or above $C000 give rom_ce = 0.
- R8: Accesses to the console RAM range $C800–$CBFF, and to non-hotspot addresses such as $C004, never assert rom_ce and do not change the selected bank.
- R9: Whenever rom_ce is 0, rom_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_valid | input | 1 | Qualifies the current bus cycle |
| rom_addr | output | 17 | Physical ROM address (width derived from BANK_W) |
| rom_ce | output | 1 | ROM chip enable, active high |

## Verification
The assertions are checked on every cycle. They cover the enable qualification (valid read below $C000 only), the RAM range never being claimed, the zero address when disabled, the identity mapping of the base area, and that the bank register loads exactly the hotspot low bits on a qualified hotspot cycle and otherwise holds. The bench scenarios are what show the end-to-end behaviour. Those scenarios cover the window offsets for each bank, selection by a write as well as a read, and the one-cycle latency before a new bank shows in the window. They also show that an unqualified hotspot address, a RAM access or a near-miss address leaves the visible bank unchanged.

// File: rtl/bank_map_pkg.sv
`timescale 1ns/1ps
package bank_map_pkg;

    localparam int CPU_AW      = 16;
    localparam int BASE_OFS_W  = 15;
    localparam int WIN_OFS_W   = 14;
    localparam logic [CPU_AW-1:0] WIN_START = 16'h8000;
    localparam logic [CPU_AW-1:0] HOT_START = 16'hC000;
    localparam logic [CPU_AW-1:0] RAM_FIRST = 16'hC800;
    localparam logic [CPU_AW-1:0] RAM_LAST  = 16'hCBFF;

    typedef enum logic [1:0] {
        AREA_BASE    = 2'd0,
        AREA_WINDOW  = 2'd1,
        AREA_HOTSPOT = 2'd2,
        AREA_NONE    = 2'd3
    } area_e;

    function automatic int rom_width(input int bank_w);
        return $clog2(32'h8000 + ((32'd1 << bank_w) * 32'h4000));
    endfunction

    function automatic logic in_ram(input logic [CPU_AW-1:0] a);
        return (a >= RAM_FIRST) && (a <= RAM_LAST);
    endfunction

endpackage

// File: rtl/bank_area_decode.sv
`timescale 1ns/1ps
module bank_area_decode
    import bank_map_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic [CPU_AW-1:0] addr,
    output area_e             area
);
    localparam logic [CPU_AW-1:BANK_W] HOT_TAG = HOT_START[CPU_AW-1:BANK_W];

    always_comb begin
        if (!addr[CPU_AW-1])
            area = AREA_BASE;
        else if (!addr[CPU_AW-2])
            area = AREA_WINDOW;
        else if (addr[CPU_AW-1:BANK_W] == HOT_TAG)
            area = AREA_HOTSPOT;
        else
            area = AREA_NONE;
    end
endmodule

// File: rtl/bank_select_reg.sv
`timescale 1ns/1ps
module bank_select_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] sel_in,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (load)
            bank_q <= sel_in;
    end

    // R1
    a_r1_reset_bank: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> bank_q == '0);
    // R4, R5
    a_r4_hotspot_loads: assert property (@(posedge clk) disable iff (rst)
        load |=> bank_q == $past(sel_in));
    // R6
    a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bank_q));
endmodule

// File: rtl/rom_addr_xlate.sv
`timescale 1ns/1ps
module rom_addr_xlate
    import bank_map_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROM_AW = 17
) (
    input  area_e                 area,
    input  logic [BASE_OFS_W-1:0] ofs,
    input  logic [BANK_W-1:0]     bank,
    input  logic                  rd_cycle,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic                  rom_ce
);
    logic [ROM_AW-1:0] win_addr;

    always_comb begin
        win_addr = ROM_AW'(WIN_START)
                 + (ROM_AW'(bank) << WIN_OFS_W)
                 + ROM_AW'(ofs[WIN_OFS_W-1:0]);
        rom_ce   = 1'b0;
        rom_addr = '0;
        if (rd_cycle) begin
            unique case (area)
                AREA_BASE: begin
                    rom_ce   = 1'b1;
                    rom_addr = ROM_AW'(ofs);
                end
                AREA_WINDOW: begin
                    rom_ce   = 1'b1;
                    rom_addr = win_addr;
                end
                default: begin
                    rom_ce   = 1'b0;
                    rom_addr = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hotspot_bank_mapper.sv
`timescale 1ns/1ps
module hotspot_bank_mapper
    import bank_map_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int ROM_AW = rom_width(BANK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rw,
    input  logic              bus_valid,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce
);
    area_e             area;
    logic [BANK_W-1:0] bank;
    logic              hot_load;
    logic              rd_cycle;

    bank_area_decode #(.BANK_W(BANK_W)) u_decode (
        .addr (cpu_addr),
        .area (area)
    );

    assign hot_load = bus_valid && (area == AREA_HOTSPOT);
    assign rd_cycle = bus_valid && cpu_rw;

    bank_select_reg #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (hot_load),
        .sel_in (cpu_addr[BANK_W-1:0]),
        .bank_q (bank)
    );

    rom_addr_xlate #(.BANK_W(BANK_W), .ROM_AW(ROM_AW)) u_xlate (
        .area     (area),
        .ofs      (cpu_addr[BASE_OFS_W-1:0]),
        .bank     (bank),
        .rd_cycle (rd_cycle),
        .rom_addr (rom_addr),
        .rom_ce   (rom_ce)
    );

    // R2
    a_r2_base_identity: assert property (@(posedge clk) disable iff (rst)
        (rom_ce && !cpu_addr[15]) |-> rom_addr == ROM_AW'(cpu_addr));
    // R3
    a_r3_window_above_base: assert property (@(posedge clk) disable iff (rst)
        (rom_ce && cpu_addr[15]) |-> rom_addr >= ROM_AW'(WIN_START));
    // R7
    a_r7_ce_qualified: assert property (@(posedge clk) disable iff (rst)
        rom_ce |-> (bus_valid && cpu_rw && cpu_addr < HOT_START));
    // R8
    a_r8_ram_unclaimed: assert property (@(posedge clk) disable iff (rst)
        in_ram(cpu_addr) |-> !rom_ce);
    // R9
    a_r9_idle_addr_zero: assert property (@(posedge clk) disable iff (rst)
        !rom_ce |-> rom_addr == '0);
endmodule

// File: tb/hotspot_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module hotspot_bank_mapper_tb_top;
    localparam int ROM_AW = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       cpu_addr = '0;
    logic              cpu_rw = 1'b1;
    logic              bus_valid = 1'b0;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_ce;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_bank = 0;

    always #2.5 clk = ~clk;

    hotspot_bank_mapper #(.BANK_W(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .bus_valid (bus_valid),
        .rom_addr  (rom_addr),
        .rom_ce    (rom_ce)
    );

    function automatic logic [ROM_AW-1:0] model_addr(input logic [15:0] a, input int b);
        if (a < 16'h8000) return ROM_AW'(a);
        return ROM_AW'(32'h8000 + b * 32'h4000 + int'(a[13:0]));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, sample before the next rising edge.
    task automatic cycle(input logic [15:0] a, input logic rw, input logic v);
        @(negedge clk);
        cpu_addr  = a;
        cpu_rw    = rw;
        bus_valid = v;
        #1;
    endtask

    task automatic expect_read(input logic [15:0] a, input string tag);
        cycle(a, 1'b1, 1'b1);
        check(rom_ce == 1'b1, tag, rom_ce, 1);
        check(rom_addr == model_addr(a, exp_bank), tag, rom_addr, model_addr(a, exp_bank));
    endtask

    task automatic expect_off(input logic [15:0] a, input logic rw, input logic v, input string tag);
        cycle(a, rw, v);
        check(rom_ce == 1'b0, tag, rom_ce, 0);
        check(rom_addr == '0, {tag, " R9"}, rom_addr, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_bank = 0;
        expect_off(16'h8123, 1'b1, 1'b0, "R9 idle after reset");
        expect_read(16'h8123, "R1 window after reset");
    endtask

    task automatic t_base;
        expect_read(16'h0000, "R2 base low");
        expect_read(16'h7FFF, "R2 base top");
        expect_read(16'h1234, "R2 base mid");
    endtask

    task automatic t_hot_read;
        for (int b = 0; b < 4; b++) begin
            expect_off(16'hC000 + 16'(b), 1'b1, 1'b1, "R7 hotspot read no ce");
            exp_bank = b;
            expect_read(16'h8000, "R4 R3 window start");
            expect_read(16'hBFFF, "R4 R3 window end");
            expect_read(16'h0400, "R2 base under bank");
        end
    endtask

    task automatic t_hot_write;
        expect_off(16'hC002, 1'b0, 1'b1, "R5 hotspot write no ce");
        exp_bank = 2;
        expect_read(16'h9000, "R5 write selects bank 2");
        check(rom_addr == 17'h11000, "R3 bank2 9000", rom_addr, 32'h11000);
    endtask

    task automatic t_timing;
        expect_off(16'hC003, 1'b1, 1'b1, "R6 hotspot");
        exp_bank = 3;
        expect_read(16'hA000, "R6 next cycle bank 3");
        check(rom_addr == 17'h16000, "R6 bank3 A000", rom_addr, 32'h16000);
        expect_off(16'hC001, 1'b1, 1'b0, "R6 unqualified hotspot");
        expect_read(16'hA000, "R6 unqualified keeps bank");
    endtask

    task automatic t_ce;
        expect_off(16'h1000, 1'b0, 1'b1, "R7 write to base");
        expect_off(16'h9000, 1'b0, 1'b1, "R7 write to window");
        expect_off(16'hD000, 1'b1, 1'b1, "R7 read above window");
        expect_off(16'h2000, 1'b1, 1'b0, "R7 invalid read");
        expect_read(16'h9000, "R7 write did not change bank");
    endtask

    task automatic t_ram;
        expect_off(16'hC800, 1'b1, 1'b1, "R8 ram first");
        expect_off(16'hCBFF, 1'b1, 1'b1, "R8 ram last");
        expect_off(16'hCA01, 1'b0, 1'b1, "R8 ram write");
        expect_off(16'hC004, 1'b1, 1'b1, "R8 near miss");
        expect_off(16'hC805, 1'b1, 1'b1, "R8 ram aliasing bits");
        expect_read(16'hB000, "R8 bank unchanged");
    endtask

    initial begin
        t_reset();
        t_base();
        t_hot_read();
        t_hot_write();
        t_timing();
        t_ce();
        t_ram();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule